// File: doc/BRIEF.md
# Two-Stack Unit with Registered Top Element

This block holds a 16-bit data stack and a 16-bit return stack for a small stack-machine core. The topmost data value lives in its own register and is always present on the `tos` output. Every deeper data value lives in a pointer-managed storage array that grows toward lower addresses. A push therefore writes the old register contents into the array. A pop refills the register from the array.

A controller issues one operation per cycle. It drives `op_valid` together with a 4-bit code and, for a push, a 16-bit operand. The block executes the operation in that clock edge. It reports the new top value, the value directly below it and the top of the return stack. It also reports a code saying whether the operation succeeded or why it was refused.

The return stack has no separate top register. Values reach it only through three transfer operations with the data stack. Every refused operation leaves both stacks exactly as they were, so an empty stack never pulls stale storage into the top register.

Top module: `dual_stack_unit`

## Requirements
- R1: One cycle after synchronous reset is released, `tos`, `nos`, `rtop` and `err_code` are all zero, and both stacks hold no stored entries.
- R2: Code 1 (push) moves the old top value below the top and makes `op_data` the new `tos`, all in the clock edge where `op_valid` is high.
- R3: Code 2 (drop) discards the top value. The value that was `nos` becomes `tos`, and the stored depth falls by one.
- R4: Code 3 (duplicate) pushes a copy of the top value, so afterwards `tos` and `nos` are both equal to the old `tos`.
- R5: Code 4 (swap) exchanges `tos` and `nos`, and the depth does not change.
- R6: Code 5 (rotate) turns the three topmost values (c b a, with a on top) into (b a c), so the third value comes to the top.
- R7: Code 6 (reverse rotate) turns (c b a) into (a c b).
- R8: Code 7 (move to return) pushes `tos` onto the return stack and then drops it from the data stack.
- R9: Code 8 (move from return) pops the return stack and pushes that value onto the data stack as the new `tos`.
- R10: Code 9 (copy from return) pushes the top of the return stack onto the data stack and leaves the return stack unchanged.
- R11: `err_code` is registered and changes only on cycles where `op_valid` is high. It reads 0 on success, 2 when the data storage is full (32 stored entries plus the top register), 3 when the return stack is full (16 entries), 4 when the data stack holds too few values and 5 when the return stack is empty. When both stacks would fail, the return-stack condition is reported.
- R12: A refused operation changes neither stack. In particular, a drop with nothing stored keeps `tos` as it was and reports 4.
- R13: Codes 0 and 10 to 15 change neither stack and report 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute `op_code` at this edge |
| op_code | input | 4 | Operation code |
| op_data | input | 16 | Value for a push |
| tos | output | 16 | Top data value (register) |
| nos | output | 16 | Value below the top, zero when none is stored |
| rtop | output | 16 | Top of the return stack, zero when it is empty |
| err_code | output | 3 | Result code of the last executed operation |

## Verification
The hardest case to reach is the one where two limits meet. Examples are a move-from-return while the data storage is completely full, or a rotate with exactly one stored entry. Reaching these needs dozens of operations in a precise order. The stimulus therefore first runs a directed sequence. It fills the data storage, moves half of it to the return stack, refills the data side and then probes every refusal. After that, random phases with push-heavy, balanced and pop-heavy weights push the depth repeatedly against both ends.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_PUSH   = 4'd1,
    OP_DROP   = 4'd2,
    OP_DUP    = 4'd3,
    OP_SWAP   = 4'd4,
    OP_ROT    = 4'd5,
    OP_NROT   = 4'd6,
    OP_TO_R   = 4'd7,
    OP_R_FROM = 4'd8,
    OP_R_COPY = 4'd9
  } stk_op_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_D_OVF = 3'd2,
    ERR_R_OVF = 3'd3,
    ERR_D_UNF = 3'd4,
    ERR_R_UNF = 3'd5
  } stk_err_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grow,
  input  logic          shrink,
  output logic [PW-1:0] ptr,
  output logic          empty,
  output logic          full
);

  localparam logic [PW-1:0] TOP = PW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst)         ptr <= TOP;
    else if (grow)   ptr <= ptr - PW'(1);
    else if (shrink) ptr <= ptr + PW'(1);
  end

  assign empty = (ptr == TOP);
  assign full  = (ptr == '0);

  // a stack moves by at most one entry per cycle
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    !(grow && shrink));

endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];

endmodule

// File: rtl/dual_stack_unit.sv
module dual_stack_unit #(
  parameter int W      = 16,
  parameter int DDEPTH = 32,
  parameter int RDEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] op_data,
  output logic [W-1:0] tos,
  output logic [W-1:0] nos,
  output logic [W-1:0] rtop,
  output logic [2:0]   err_code
);
  import stk_pkg::*;

  localparam int DAW   = $clog2(DDEPTH);
  localparam int DPW   = $clog2(DDEPTH + 1);
  localparam int RAW   = $clog2(RDEPTH);
  localparam int RPW   = $clog2(RDEPTH + 1);
  localparam int BANKD = DDEPTH / 2;

  stk_op_e      op;
  stk_err_e     err_q, err_n;
  logic [W-1:0] tos_q, tos_n;

  logic           d_grow, d_shrink, r_grow, r_shrink;
  logic [DPW-1:0] dptr;
  logic [RPW-1:0] rptr;
  logic           d_empty, d_full, r_empty, r_full, d_two;
  logic [DAW-1:0] d_at, d_below, d_above;
  logic [RAW-1:0] r_at, r_below;

  logic           dw0_en, dw1_en, rw_en;
  logic [DAW-1:0] dw0_a, dw1_a;
  logic [W-1:0]   dw0_d, dw1_d;
  logic [W-1:0]   rd0, rd1, r_rd;

  logic           bank_we [2];
  logic [DAW-2:0] bank_wa [2];
  logic [DAW-2:0] bank_ra [2];
  logic [W-1:0]   bank_wd [2];
  logic [W-1:0]   bank_rd [2];

  assign op = stk_op_e'(op_code);

  stk_ptr #(.DEPTH(DDEPTH)) u_dptr (
    .clk(clk), .rst(rst), .grow(d_grow), .shrink(d_shrink),
    .ptr(dptr), .empty(d_empty), .full(d_full));

  stk_ptr #(.DEPTH(RDEPTH)) u_rptr (
    .clk(clk), .rst(rst), .grow(r_grow), .shrink(r_shrink),
    .ptr(rptr), .empty(r_empty), .full(r_full));

  assign d_at    = dptr[DAW-1:0];
  assign d_below = d_at - DAW'(1);
  assign d_above = d_at + DAW'(1);
  assign d_two   = (dptr <= DPW'(DDEPTH - 2));
  assign r_at    = rptr[RAW-1:0];
  assign r_below = r_at - RAW'(1);

  // data storage split by address parity: the two entries below the top
  // always fall in different banks, so each bank needs one port of each kind
  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic SEL = 1'(b);
    logic hit0, hit1;
    assign hit0       = dw0_en && (dw0_a[0] == SEL);
    assign hit1       = dw1_en && (dw1_a[0] == SEL);
    assign bank_we[b] = hit0 || hit1;
    assign bank_wa[b] = hit0 ? dw0_a[DAW-1:1] : dw1_a[DAW-1:1];
    assign bank_wd[b] = hit0 ? dw0_d : dw1_d;
    assign bank_ra[b] = (d_at[0] == SEL) ? d_at[DAW-1:1] : d_above[DAW-1:1];

    stk_store #(.W(W), .DEPTH(BANKD)) u_bank (
      .clk(clk), .we(bank_we[b]), .wa(bank_wa[b]), .wd(bank_wd[b]),
      .ra(bank_ra[b]), .rd(bank_rd[b]));

    assert_bank_one_writer_R6: assert property (@(posedge clk) disable iff (rst)
      !(hit0 && hit1));
  end

  assign rd0 = d_at[0] ? bank_rd[1] : bank_rd[0];
  assign rd1 = d_at[0] ? bank_rd[0] : bank_rd[1];

  stk_store #(.W(W), .DEPTH(RDEPTH)) u_rmem (
    .clk(clk), .we(rw_en), .wa(r_below), .wd(tos_q), .ra(r_at), .rd(r_rd));

  always_comb begin
    tos_n    = tos_q;
    err_n    = ERR_NONE;
    d_grow   = 1'b0;
    d_shrink = 1'b0;
    r_grow   = 1'b0;
    r_shrink = 1'b0;
    dw0_en   = 1'b0;
    dw0_a    = d_at;
    dw0_d    = tos_q;
    dw1_en   = 1'b0;
    dw1_a    = d_above;
    dw1_d    = rd0;
    rw_en    = 1'b0;
    if (op_valid) begin
      case (op)
        OP_PUSH, OP_DUP: begin
          if (d_full) err_n = ERR_D_OVF;
          else begin
            d_grow = 1'b1;
            dw0_en = 1'b1;
            dw0_a  = d_below;
            tos_n  = (op == OP_PUSH) ? op_data : tos_q;
          end
        end
        OP_DROP: begin
          if (d_empty) err_n = ERR_D_UNF;
          else begin
            tos_n    = rd0;
            d_shrink = 1'b1;
          end
        end
        OP_SWAP: begin
          if (d_empty) err_n = ERR_D_UNF;
          else begin
            dw0_en = 1'b1;
            tos_n  = rd0;
          end
        end
        OP_ROT: begin
          if (!d_two) err_n = ERR_D_UNF;
          else begin
            tos_n  = rd1;
            dw0_en = 1'b1;
            dw1_en = 1'b1;
          end
        end
        OP_NROT: begin
          if (!d_two) err_n = ERR_D_UNF;
          else begin
            tos_n  = rd0;
            dw0_en = 1'b1;
            dw0_d  = rd1;
            dw1_en = 1'b1;
            dw1_d  = tos_q;
          end
        end
        OP_TO_R: begin
          if (r_full)       err_n = ERR_R_OVF;
          else if (d_empty) err_n = ERR_D_UNF;
          else begin
            rw_en    = 1'b1;
            r_grow   = 1'b1;
            tos_n    = rd0;
            d_shrink = 1'b1;
          end
        end
        OP_R_FROM, OP_R_COPY: begin
          if (r_empty)     err_n = ERR_R_UNF;
          else if (d_full) err_n = ERR_D_OVF;
          else begin
            d_grow   = 1'b1;
            dw0_en   = 1'b1;
            dw0_a    = d_below;
            tos_n    = r_rd;
            r_shrink = (op == OP_R_FROM);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q <= '0;
      err_q <= ERR_NONE;
    end else if (op_valid) begin
      tos_q <= tos_n;
      err_q <= err_n;
    end
  end

  assign tos      = tos_q;
  assign nos      = d_empty ? '0 : rd0;
  assign rtop     = r_empty ? '0 : r_rd;
  assign err_code = err_q;

  assert_push_value_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_PUSH && !d_full |=> tos_q == $past(op_data) && nos == $past(tos_q));

  assert_dup_match_R4: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_DUP && !d_full |=> nos == tos_q);

  assert_swap_exchange_R5: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_SWAP && !d_empty |=> tos_q == $past(nos) && nos == $past(tos_q));

  assert_to_return_R8: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_TO_R && !r_full && !d_empty |=> rtop == $past(tos_q));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(err_q) && $stable(tos_q));

  assert_ptr_bound_R11: assert property (@(posedge clk) disable iff (rst)
    dptr <= DPW'(DDEPTH) && rptr <= RPW'(RDEPTH));

  assert_empty_drop_R12: assert property (@(posedge clk) disable iff (rst)
    op_valid && op == OP_DROP && d_empty |=> tos_q == $past(tos_q) && err_q == ERR_D_UNF);

endmodule

// File: tb/dual_stack_unit_test.sv
`timescale 1ns/1ps
module dual_stack_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [15:0] op_data = 16'd0;
  logic [15:0] tos, nos, rtop;
  logic [2:0]  err_code;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_tos;
  logic [15:0] dl [32];
  logic [15:0] rl [16];
  int          m_dn, m_rn;
  logic [2:0]  m_err;

  always #10 clk = ~clk;

  dual_stack_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_data(op_data), .tos(tos), .nos(nos), .rtop(rtop), .err_code(err_code));

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "tos", tos, m_tos);
    chk(tag, "nos", nos, (m_dn > 0) ? dl[0] : 16'd0);
    chk(tag, "rtop", rtop, (m_rn > 0) ? rl[0] : 16'd0);
    chk(tag, "err", {13'd0, err_code}, {13'd0, m_err});
  endtask

  function automatic string tag_of(logic [3:0] op, logic [2:0] e);
    if (e != 3'd0) return "R11 R12";
    case (op)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic d_push(logic [15:0] v);
    for (int i = 31; i > 0; i--) dl[i] = dl[i-1];
    dl[0] = m_tos;
    m_dn++;
    m_tos = v;
  endtask

  task automatic d_pop();
    m_tos = dl[0];
    for (int i = 0; i < 31; i++) dl[i] = dl[i+1];
    m_dn--;
  endtask

  task automatic model_step(logic [3:0] op, logic [15:0] v);
    logic [15:0] t;
    m_err = 3'd0;
    case (op)
      4'd1, 4'd3: if (m_dn == 32) m_err = 3'd2; else d_push(op == 4'd1 ? v : m_tos);
      4'd2: if (m_dn == 0) m_err = 3'd4; else d_pop();
      4'd4: if (m_dn < 1) m_err = 3'd4; else begin t = m_tos; m_tos = dl[0]; dl[0] = t; end
      4'd5: if (m_dn < 2) m_err = 3'd4; else begin
              t = m_tos; m_tos = dl[1]; dl[1] = dl[0]; dl[0] = t; end
      4'd6: if (m_dn < 2) m_err = 3'd4; else begin
              t = m_tos; m_tos = dl[0]; dl[0] = dl[1]; dl[1] = t; end
      4'd7: if (m_rn == 16) m_err = 3'd3;
            else if (m_dn == 0) m_err = 3'd4;
            else begin
              for (int i = 15; i > 0; i--) rl[i] = rl[i-1];
              rl[0] = m_tos; m_rn++;
              d_pop();
            end
      4'd8, 4'd9: if (m_rn == 0) m_err = 3'd5;
            else if (m_dn == 32) m_err = 3'd2;
            else begin
              d_push(rl[0]);
              if (op == 4'd8) begin
                for (int i = 0; i < 15; i++) rl[i] = rl[i+1];
                m_rn--;
              end
            end
      default: ;
    endcase
  endtask

  task automatic apply(logic [3:0] op, logic [15:0] v);
    op_valid = 1'b1;
    op_code  = op;
    op_data  = v;
    model_step(op, v);
    @(negedge clk);
    op_valid = 1'b0;
    chk_all(tag_of(op, m_err));
  endtask

  task automatic idle(logic [3:0] op, logic [15:0] v);
    op_valid = 1'b0;
    op_code  = op;
    op_data  = v;
    @(negedge clk);
    chk_all("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    m_tos = 16'd0; m_dn = 0; m_rn = 0; m_err = 3'd0;
    for (int i = 0; i < 32; i++) dl[i] = 16'd0;
    for (int i = 0; i < 16; i++) rl[i] = 16'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1");

    // refusals on empty stacks (R12, R11)
    apply(4'd2, 16'h0);
    apply(4'd8, 16'h0);
    apply(4'd9, 16'h0);
    apply(4'd4, 16'h0);
    apply(4'd7, 16'h0);
    apply(4'd1, 16'hA001);
    apply(4'd5, 16'h0);
    apply(4'd6, 16'h0);
    apply(4'd1, 16'hB002);
    apply(4'd1, 16'hC003);
    apply(4'd5, 16'h0);
    apply(4'd6, 16'h0);
    apply(4'd6, 16'h0);
    apply(4'd4, 16'h0);
    apply(4'd3, 16'h0);
    apply(4'd12, 16'hFFFF);
    idle(4'd1, 16'h1234);
    // fill data storage to the limit, then overflow (R11)
    for (int i = 0; m_dn < 32; i++) apply(4'd1, 16'(16'h1000 + i));
    apply(4'd1, 16'hDEAD);
    apply(4'd3, 16'h0);
    // move half to the return stack until it is full
    for (int i = 0; i < 16; i++) apply(4'd7, 16'h0);
    apply(4'd7, 16'h0);
    apply(4'd10, 16'h0);
    for (int i = 0; m_dn < 32; i++) apply(4'd1, 16'(16'h2000 + i));
    apply(4'd8, 16'h0);
    apply(4'd9, 16'h0);
    apply(4'd2, 16'h0);
    apply(4'd9, 16'h0);
    apply(4'd2, 16'h0);
    apply(4'd8, 16'h0);
    apply(4'd2, 16'h0);
    apply(4'd2, 16'h0);
    for (int i = 0; i < 17; i++) apply(4'd8, 16'h0);
    for (int i = 0; i < 40; i++) apply(4'd2, 16'h0);

    // random phases: push-heavy, balanced, pop-heavy
    for (int ph = 0; ph < 3; ph++) begin
      for (int n = 0; n < 600; n++) begin
        int r;
        logic [3:0] op;
        r = int'($urandom % 100);
        if (r < 35 - ph * 12)      op = 4'd1;
        else if (r < 50 - ph * 6)  op = (r % 2 == 0) ? 4'd3 : 4'd9;
        else if (r < 60)           op = 4'd2;
        else if (r < 68)           op = 4'd7;
        else if (r < 74)           op = 4'd8;
        else                       op = 4'($urandom % 16);
        if (op == 4'd1 && ph == 2 && (n % 3 != 0)) op = 4'd2;
        if ($urandom % 8 == 0) idle(op, 16'($urandom));
        else apply(op, 16'($urandom));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule